// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact in-order processor core that splits each instruction into five steps: fetch, decode with register read, execute, memory access and writeback. A register bank sits between each pair of neighbouring steps, so up to five instructions are in flight at once. The core runs a small instruction subset: register add, register NAND, word load and word store. It has eight 32-bit general registers.

Instruction and data storage are small word arrays inside the block. A load port fills both arrays, and the bench uses it while reset is held. No hazard detection and no forwarding between stages exist. Programs must keep at least two unrelated instructions between an instruction that writes a register and one that reads it.

A debug port returns any register's value and shows which inter-stage banks hold a fetched instruction.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC returns to 0. All four inter-stage banks become empty bubbles that neither write registers nor touch memory, so `dbg_stage_valid` reads 0. All eight registers clear to 0.
- R2: Each rising edge out of reset fetches the word at PC/4 and adds 4 to the PC. Occupancy moves one stage per edge. In `dbg_stage_valid`, bit 0 is the fetch/decode bank, bit 1 decode/execute, bit 2 execute/memory and bit 3 memory/writeback.
- R3: Opcode field [31:26]=0 with function field [5:0]=0x20 and shift field [10:6]=0 writes rs+rt into rd. Source fields are rs=[25:21] and rt=[20:16]; the destination field is rd=[15:11].
- R4: Opcode 0 with function 0x2F and shift field 0 writes the bitwise inverse of (rs AND rt) into rd.
- R5: Opcode 0x23 loads the data word at byte address rs + sign-extended [15:0] into rt.
- R6: Opcode 0x2B stores rt to the data word at byte address rs + sign-extended [15:0]. Misaligned or out-of-range data addresses store nothing and load zero.
- R7: The word at instruction index i, fetched on rising edge i+1 after reset release, updates its destination register on rising edge i+5.
- R8: Register 0, and any register number of 8 or more, reads as zero and ignores writes.
- R9: A register written back on an edge is seen by an instruction that reads it in decode during the cycle ending at that same edge.
- R10: Fetching at or past the end of instruction storage injects empty bubbles. Earlier instructions still complete, and occupancy drains to 0.
- R11: Any other encoding, including the all-zero word and a nonzero shift field, changes no register and no memory word.
- R12: `ld_imem_we` or `ld_dmem_we` writes `ld_data` into word `ld_addr` of instruction or data storage on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_imem_we | input | 1 | Write `ld_data` into instruction storage |
| ld_dmem_we | input | 1 | Write `ld_data` into data storage |
| ld_addr | input | LDW (5) | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| dbg_reg_sel | input | RAW (3) | Register number to observe |
| dbg_reg_val | output | 32 | Stored value of the selected register |
| dbg_stage_valid | output | 4 | Occupancy of the four inter-stage banks |

## Verification
Word i of the program is fetched on edge i+1 after reset release, crosses one bank per edge, and appears in the register file on edge i+5. The bench counts edges from release and reads the affected register both one edge before and on that edge. This pins the latency of the add, NAND and load paths exactly, and also the same-edge write/read case. Occupancy is sampled on the edges where the fetch first runs past storage and where the last bubble reaches writeback. A final register table covers the effects of stores, ignored encodings and register 0.

// File: rtl/p5_pkg.sv
// Shared constants, control word and decoder for the five-stage core.
// Assumes 32-bit instructions and data words.
package p5_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_NAND  = 6'h2F;

    // Control bits carried down the pipe with each instruction.
    typedef struct packed {
        logic reg_we;
        logic mem_rd;
        logic mem_wr;
        logic use_imm;
        logic do_nand;
    } ctl_t;

    localparam ctl_t CTL_BUBBLE = '0;

    // Turn opcode, function and shift fields into control bits; anything unknown is a bubble.
    function automatic ctl_t decode_ctl(input logic [5:0] op, input logic [5:0] fn,
                                        input logic [4:0] sh);
        ctl_t c;
        c = CTL_BUBBLE;
        case (op)
            OP_REG: begin
                if (sh == 5'd0 && fn == FN_ADD) begin
                    c.reg_we = 1'b1;
                end else if (sh == 5'd0 && fn == FN_NAND) begin
                    c.reg_we  = 1'b1;
                    c.do_nand = 1'b1;
                end
            end
            OP_LOAD: begin
                c.reg_we  = 1'b1;
                c.mem_rd  = 1'b1;
                c.use_imm = 1'b1;
            end
            OP_STORE: begin
                c.mem_wr  = 1'b1;
                c.use_imm = 1'b1;
            end
            default: c = CTL_BUBBLE;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/p5_fetch.sv
// Fetch stage: PC, instruction storage and the fetch/decode bank.
// Assumes word-aligned PCs; a PC beyond storage yields a bubble word.
module p5_fetch
    import p5_pkg::*;
#(
    parameter int IM_DEPTH = 32,
    parameter int LDW      = 5,
    localparam int IAW     = $clog2(IM_DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic [LDW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    output logic [XLEN-1:0] cur_pc,
    output logic [XLEN-1:0] fd_ins,
    output logic [XLEN-1:0] fd_pc4,
    output logic            fd_vld
);
    logic [XLEN-1:0] imem [IM_DEPTH];
    logic            in_range;
    logic [XLEN-1:0] word_now;

    // Load port writes into instruction storage.
    always_ff @(posedge clk) begin
        if (ld_we) imem[ld_addr[IAW-1:0]] <= ld_data;
    end

    // Select the word at the PC, or a bubble past the end.
    always_comb begin
        in_range = (cur_pc >> 2) < XLEN'(IM_DEPTH);
        word_now = in_range ? imem[cur_pc[IAW+1:2]] : '0;
    end

    // Advance the PC and fill the fetch/decode bank every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_pc <= '0;
            fd_ins <= '0;
            fd_pc4 <= '0;
            fd_vld <= 1'b0;
        end else begin
            cur_pc <= cur_pc + XLEN'(4);
            fd_ins <= word_now;
            fd_pc4 <= cur_pc + XLEN'(4);
            fd_vld <= in_range;
        end
    end
endmodule

// File: rtl/p5_regfile.sv
// Register bank with two read ports, one write port and a debug read.
// Assumes 5-bit register fields; numbers 0 and >= NREG read zero.
// A write on this edge is returned to readers in the same cycle.
module p5_regfile
    import p5_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [4:0]      ra_idx,
    input  logic [4:0]      rb_idx,
    output logic [XLEN-1:0] ra_val,
    output logic [XLEN-1:0] rb_val,
    input  logic            wr_en,
    input  logic [4:0]      wr_idx,
    input  logic [XLEN-1:0] wr_val,
    input  logic [RAW-1:0]  dbg_idx,
    output logic [XLEN-1:0] dbg_val
);
    logic [XLEN-1:0] regs [NREG];
    logic [4:0]      rd_idx [2];
    logic [XLEN-1:0] rd_val [2];
    logic            wr_ok;

    assign rd_idx[0] = ra_idx;
    assign rd_idx[1] = rb_idx;
    assign ra_val    = rd_val[0];
    assign rb_val    = rd_val[1];
    assign wr_ok     = wr_en && (wr_idx != 5'd0) && (32'(wr_idx) < NREG);

    // One read path per port, with same-cycle bypass from the write port.
    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (rd_idx[p] == 5'd0 || 32'(rd_idx[p]) >= NREG)
                rd_val[p] = '0;
            else if (wr_ok && wr_idx == rd_idx[p])
                rd_val[p] = wr_val;
            else
                rd_val[p] = regs[rd_idx[p][RAW-1:0]];
        end
    end

    // Clear on reset, otherwise take the writeback value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_ok) begin
            regs[wr_idx[RAW-1:0]] <= wr_val;
        end
    end

    // Debug view of the stored contents.
    assign dbg_val = regs[dbg_idx];
endmodule

// File: rtl/p5_alu.sv
// Execute-stage arithmetic: sum or inverted AND of two operands.
module p5_alu
    import p5_pkg::*;
(
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            do_nand,
    output logic [XLEN-1:0] res
);
    // Pick the operation requested by the control bits.
    always_comb res = do_nand ? ~(opa & opb) : opa + opb;
endmodule

// File: rtl/p5_dmem.sv
// Data storage: byte-addressed word array with a load port.
// Assumes word accesses; misaligned or out-of-range addresses read zero and never write.
module p5_dmem
    import p5_pkg::*;
#(
    parameter int DM_DEPTH = 32,
    parameter int LDW      = 5,
    localparam int DAW     = $clog2(DM_DEPTH)
) (
    input  logic            clk,
    input  logic            ld_we,
    input  logic [LDW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [XLEN-1:0] addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] dmem [DM_DEPTH];
    logic            hit;

    assign hit     = (addr[1:0] == 2'b00) && ((addr >> 2) < XLEN'(DM_DEPTH));
    assign rd_data = hit ? dmem[addr[DAW+1:2]] : '0;

    // Load port first, else the store from the memory stage.
    always_ff @(posedge clk) begin
        if (ld_we)
            dmem[ld_addr[DAW-1:0]] <= ld_data;
        else if (wr_en && hit)
            dmem[addr[DAW+1:2]] <= wr_data;
    end
endmodule

// File: rtl/pipe5_core.sv
// Five-stage in-order core: fetch, decode, execute, memory, writeback.
// Assumes software-scheduled code with no register hazards closer than
// three instructions; no stalls, forwarding or branches.
module pipe5_core
    import p5_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int IM_DEPTH = 32,
    parameter int DM_DEPTH = 32,
    localparam int RAW     = $clog2(NREG),
    localparam int IAW     = $clog2(IM_DEPTH),
    localparam int DAW     = $clog2(DM_DEPTH),
    localparam int LDW     = (IAW > DAW) ? IAW : DAW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_imem_we,
    input  logic            ld_dmem_we,
    input  logic [LDW-1:0]  ld_addr,
    input  logic [XLEN-1:0] ld_data,
    input  logic [RAW-1:0]  dbg_reg_sel,
    output logic [XLEN-1:0] dbg_reg_val,
    output logic [3:0]      dbg_stage_valid
);
    // fetch/decode bank
    logic [XLEN-1:0] pc, fd_ins, fd_pc4;
    logic            fd_vld;
    // decode signals
    ctl_t            dc_ctl;
    logic [4:0]      dc_dst;
    logic [XLEN-1:0] dc_imm, dc_a, dc_b;
    // decode/execute bank
    ctl_t            de_ctl;
    logic [4:0]      de_dst;
    logic [XLEN-1:0] de_imm, de_a, de_b, de_pc4;
    logic            de_vld;
    // execute signals and execute/memory bank
    logic [XLEN-1:0] ex_res;
    ctl_t            em_ctl;
    logic [4:0]      em_dst;
    logic [XLEN-1:0] em_res, em_sd;
    logic            em_vld;
    // memory signals and memory/writeback bank
    logic [XLEN-1:0] mem_rd;
    ctl_t            mw_ctl;
    logic [4:0]      mw_dst;
    logic [XLEN-1:0] mw_ld, mw_res;
    logic            mw_vld;
    // writeback
    logic            wb_we;
    logic [XLEN-1:0] wb_val;

    p5_fetch #(.IM_DEPTH(IM_DEPTH), .LDW(LDW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_imem_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .cur_pc(pc), .fd_ins(fd_ins), .fd_pc4(fd_pc4),
        .fd_vld(fd_vld)
    );

    // Decode fields and control bits from the fetched word.
    always_comb begin
        dc_ctl = decode_ctl(fd_ins[31:26], fd_ins[5:0], fd_ins[10:6]);
        dc_dst = (fd_ins[31:26] == OP_REG) ? fd_ins[15:11] : fd_ins[20:16];
        dc_imm = {{(XLEN-16){fd_ins[15]}}, fd_ins[15:0]};
    end

    p5_regfile #(.NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .ra_idx(fd_ins[25:21]), .rb_idx(fd_ins[20:16]),
        .ra_val(dc_a), .rb_val(dc_b), .wr_en(wb_we), .wr_idx(mw_dst),
        .wr_val(wb_val), .dbg_idx(dbg_reg_sel), .dbg_val(dbg_reg_val)
    );

    // Decode/execute bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de_ctl <= CTL_BUBBLE;
            de_dst <= '0;
            de_imm <= '0;
            de_a   <= '0;
            de_b   <= '0;
            de_pc4 <= '0;
            de_vld <= 1'b0;
        end else begin
            de_ctl <= dc_ctl;
            de_dst <= dc_dst;
            de_imm <= dc_imm;
            de_a   <= dc_a;
            de_b   <= dc_b;
            de_pc4 <= fd_pc4;
            de_vld <= fd_vld;
        end
    end

    p5_alu u_alu (
        .opa(de_a), .opb(de_ctl.use_imm ? de_imm : de_b),
        .do_nand(de_ctl.do_nand), .res(ex_res)
    );

    // Execute/memory bank; the second operand travels on as store data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_ctl <= CTL_BUBBLE;
            em_dst <= '0;
            em_res <= '0;
            em_sd  <= '0;
            em_vld <= 1'b0;
        end else begin
            em_ctl <= de_ctl;
            em_dst <= de_dst;
            em_res <= ex_res;
            em_sd  <= de_b;
            em_vld <= de_vld;
        end
    end

    p5_dmem #(.DM_DEPTH(DM_DEPTH), .LDW(LDW)) u_dmem (
        .clk(clk), .ld_we(ld_dmem_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .addr(em_res), .wr_en(em_ctl.mem_wr), .wr_data(em_sd), .rd_data(mem_rd)
    );

    // Memory/writeback bank; load data only captured for loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_ctl <= CTL_BUBBLE;
            mw_dst <= '0;
            mw_ld  <= '0;
            mw_res <= '0;
            mw_vld <= 1'b0;
        end else begin
            mw_ctl <= em_ctl;
            mw_dst <= em_dst;
            mw_ld  <= em_ctl.mem_rd ? mem_rd : '0;
            mw_res <= em_res;
            mw_vld <= em_vld;
        end
    end

    // Writeback source select.
    always_comb begin
        wb_we  = mw_ctl.reg_we;
        wb_val = mw_ctl.mem_rd ? mw_ld : mw_res;
    end

    assign dbg_stage_valid = {mw_vld, em_vld, de_vld, fd_vld};
endmodule

// File: rtl/pipe5_core_chk.sv
// Property checker for pipe5_core, attached by bind below.
module pipe5_core_chk
    import p5_pkg::*;
#(
    parameter int RAW = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc,
    input logic [3:0]      occ,
    input logic [XLEN-1:0] fd_pc4,
    input logic [XLEN-1:0] de_pc4,
    input logic            em_store,
    input logic            em_load,
    input logic            wb_we,
    input logic [RAW-1:0]  dbg_sel,
    input logic [XLEN-1:0] dbg_val
);
    // R1
    reset_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pc == '0 && occ == 4'b0000));

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pc == $past(pc) + XLEN'(4));

    // R2
    occ_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> occ[3:1] == $past(occ[2:0]));

    // R2
    pc4_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> de_pc4 == $past(fd_pc4));

    // R8
    r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == '0) |-> dbg_val == '0);

    // R10
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !occ[3] |-> !wb_we);

    // R11
    mem_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({em_store, em_load}));
endmodule

bind pipe5_core pipe5_core_chk #(.RAW(RAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .occ(dbg_stage_valid),
    .fd_pc4(fd_pc4), .de_pc4(de_pc4), .em_store(em_ctl.mem_wr),
    .em_load(em_ctl.mem_rd), .wb_we(wb_we), .dbg_sel(dbg_reg_sel),
    .dbg_val(dbg_reg_val)
);

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [2:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_val;
    logic [3:0]  dbg_stage_valid;

    int total = 0;
    int bad   = 0;
    int edges = 0;

    // Final register contents expected after the program drains.
    localparam logic [31:0] EXP_REG [8] = '{
        32'h0, 32'd22, 32'h12345678, 32'd48,
        32'd22, 32'd15, 32'hFFFFFFFD, 32'h12345678
    };

    logic [31:0] prog [32];
    logic [31:0] dinit [32];

    pipe5_core u0 (
        .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_reg_sel(dbg_reg_sel),
        .dbg_reg_val(dbg_reg_val), .dbg_stage_valid(dbg_stage_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt,
                                          input logic [5:0] fn, input int sh);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt,
                                          input int off);
        return {op, 5'(rs), 5'(rt), 16'(off)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input int idx, output logic [31:0] val);
        dbg_reg_sel = 3'(idx);
        #1;
        val = dbg_reg_val;
    endtask

    task automatic step_to(input int n);
        while (edges < n) begin
            @(posedge clk);
            #1;
            edges++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            prog[i]  = '0;
            dinit[i] = '0;
        end
        for (int k = 1; k <= 7; k++) prog[k-1] = enc_i(6'h23, 0, k, 4 * k);
        prog[7]  = enc_r(3, 1, 2, 6'h20, 0);
        prog[8]  = enc_r(6, 4, 5, 6'h2F, 0);
        prog[9]  = enc_i(6'h23, 2, 4, 20);
        prog[10] = enc_r(5, 2, 5, 6'h20, 0);
        prog[11] = enc_i(6'h2B, 3, 7, 12);
        prog[12] = enc_i(6'h23, 0, 1, 60);
        prog[13] = enc_r(0, 3, 3, 6'h20, 0);
        prog[14] = enc_i(6'h23, 3, 2, -4);
        prog[15] = enc_r(5, 1, 1, 6'h3F, 0);
        prog[16] = enc_r(4, 1, 1, 6'h20, 1);
        prog[17] = enc_r(7, 2, 0, 6'h20, 0);
        dinit[1] = 32'd40; dinit[2] = 32'd8;  dinit[3] = 32'd12; dinit[4] = 32'd18;
        dinit[5] = 32'd7;  dinit[6] = 32'd41; dinit[7] = 32'd22; dinit[11] = 32'h12345678;

        // R12: fill both storages through the load port while reset is held.
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            ld_addr = 5'(i); ld_data = prog[i]; ld_imem_we = 1'b1; ld_dmem_we = 1'b0;
            @(negedge clk);
            ld_data = dinit[i]; ld_imem_we = 1'b0; ld_dmem_we = 1'b1;
        end
        @(negedge clk);
        ld_imem_we = 1'b0; ld_dmem_we = 1'b0;

        // R1: reset state.
        chk("R1 occupancy in reset", 32'(dbg_stage_valid), 32'h0);
        for (int r = 0; r < 8; r++) begin
            peek(r, v);
            chk("R1 register clear in reset", v, 32'h0);
        end

        @(negedge clk);
        rst_n = 1'b1;
        dbg_reg_sel = 3'd1;
        step_to(1);
        chk("R2 occupancy after one edge", 32'(dbg_stage_valid), 32'h1);
        step_to(4);
        chk("R2 occupancy full", 32'(dbg_stage_valid), 32'hF);
        peek(1, v); chk("R7 load not yet written", v, 32'h0);
        step_to(5);
        peek(1, v); chk("R5 R7 load lands on edge 5", v, 32'd40);
        step_to(11);
        peek(3, v); chk("R7 add not yet written", v, 32'd12);
        step_to(12);
        peek(3, v); chk("R3 add result", v, 32'd48);
        peek(6, v); chk("R7 nand not yet written", v, 32'd41);
        step_to(13);
        peek(6, v); chk("R4 nand result", v, 32'hFFFFFFFD);
        step_to(17);
        peek(1, v); chk("R6 stored word read back", v, 32'd22);
        step_to(19);
        peek(2, v); chk("R5 negative offset load", v, 32'h12345678);
        step_to(22);
        peek(7, v); chk("R9 same-cycle write seen in decode", v, 32'h12345678);
        step_to(33);
        chk("R10 first bubble past storage", 32'(dbg_stage_valid), 32'hE);
        step_to(36);
        chk("R10 pipe drained", 32'(dbg_stage_valid), 32'h0);

        // Final register table (R3 R4 R5 R6 R8 R9 R11).
        for (int r = 0; r < 8; r++) begin
            peek(r, v);
            chk($sformatf("R8 R11 final register %0d", r), v, EXP_REG[r]);
        end

        // R1: reset in mid-run clears state again.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 occupancy after mid-run reset", 32'(dbg_stage_valid), 32'h0);
        peek(3, v); chk("R1 register cleared by mid-run reset", v, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule